// File: doc/BRIEF.md
# Partitionable LRU Line Buffer Set

This block keeps the bookkeeping for one indexed set of four line buffers in the read path of a flash cache. It holds a tag and a valid bit per way, a complete recency ranking of the four ways, and a registered way-configuration field. Each cycle with a lookup, it compares the requested tag against the valid ways. It reports a hit and the matching way, or it reports a miss and the way that receives the new line. Data storage, flash timing and the bus protocol belong to the surrounding cache.

On a miss the victim is the least-recently-used way among the ways the access may use. The configuration field selects pooled mode or split mode. In pooled mode every way is open to every access. In split mode, ways 0 and 1 serve instruction fetches and ways 2 and 3 serve data accesses. Lines filled by next-sequential prefetches keep the recency rank of the way they replaced. A later demand hit on such a line promotes it to most-recently-used.

Top module: `lbs_set`

## Requirements
- R1: Reset clears every valid bit, sets the recency order to way0 (least recent) < way1 < way2 < way3, and sets the configuration to 00, so the first data demand miss after reset allocates way 0.
- R2: A lookup (`req_valid`=1) whose tag equals that of a valid way drives `hit`=1, `miss`=0 and `hit_way` to that way; otherwise the lookup drives `miss`=1, `hit`=0 and `hit_way`=0.
- R3: In pooled mode (configuration 00), a miss drives `alloc_way` to the least-recently-used of all four ways, and the next cycle that way holds the new tag and is valid.
- R4: A demand lookup (`req_prefetch`=0) makes the way it hits or allocates the most-recently-used. Ways that ranked above it each move down one place.
- R5: A prefetch miss (`req_prefetch`=1) fills the victim way without changing any recency rank, so the next miss in the same group picks that way again.
- R6: A prefetch lookup that hits changes no recency rank. A later demand hit on a prefetched line promotes it to most-recently-used.
- R7: With configuration 10, an instruction miss (`req_is_insn`=1) allocates whichever of ways 0 and 1 ranks less recent. A data miss allocates whichever of ways 2 and 3 ranks less recent.
- R8: With configuration 10, a lookup hits in any way, whatever its access type.
- R9: The reserved configuration values 01 and 11 allocate as pooled mode does.
- R10: With `cfg_we`=1, `cfg_wdata` is loaded at the clock edge. It affects lookups from the next cycle on.
- R11: With `req_valid`=0, `hit`, `miss`, `hit_way` and `alloc_way` are all 0, and no tag, valid bit or rank changes.
- R12: `alloc_way` is 0 whenever `miss` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the way-configuration field |
| cfg_wdata | input | 2 | New configuration: 00 pooled, 10 split, 01/11 reserved |
| req_valid | input | 1 | Lookup request present this cycle |
| req_tag | input | TAG_W | Tag of the requested flash line |
| req_is_insn | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_prefetch | input | 1 | 1 for a next-sequential prefetch |
| hit | output | 1 | Lookup matched a valid way |
| miss | output | 1 | Lookup matched no valid way; a way is allocated |
| hit_way | output | 2 | Matching way when `hit`, else 0 |
| alloc_way | output | 2 | Way receiving the line when `miss`, else 0 |

## Verification
A corrupt recency ranking stays hidden while lookups hit. It shows at the first miss afterwards, as a wrong `alloc_way` in the same cycle as the miss. A wrong tag or valid bit shows as a wrong `hit`/`miss` on the next lookup of that line. The stimulus is therefore built so that the correct victim differs from the victim each likely fault would choose: a global LRU used in split mode, promotion of prefetch fills, split allocation under reserved codes, and a missing rank shift. Each such fault then shows within one or two lookups.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int RANK_W = $clog2(WAYS);
    localparam int HALF   = WAYS / 2;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [RANK_W-1:0] rank_t;

    localparam logic [1:0] CFG_POOL  = 2'b00;
    localparam logic [1:0] CFG_SPLIT = 2'b10;
endpackage

// File: rtl/lbs_tag_match.sv
module lbs_tag_match
    import lbs_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       any_hit,
    output way_t                       match_way
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == look_tag);
    end

    always_comb begin
        match_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (eq[i]) match_way = way_t'(i);
        end
    end

    assign any_hit = |eq;
endmodule

// File: rtl/lbs_victim_sel.sv
module lbs_victim_sel
    import lbs_pkg::*;
(
    input  logic [WAYS-1:0]             elig,
    input  logic [WAYS-1:0][RANK_W-1:0] rank,
    output way_t                        victim
);
    always_comb begin
        rank_t best_rank;
        logic  found;
        victim    = '0;
        best_rank = '1;
        found     = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (elig[i] && (!found || rank[i] < best_rank)) begin
                victim    = way_t'(i);
                best_rank = rank[i];
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbs_rank_update.sv
module lbs_rank_update
    import lbs_pkg::*;
(
    input  logic                        promote_en,
    input  way_t                        promote_way,
    input  logic [WAYS-1:0][RANK_W-1:0] rank_in,
    output logic [WAYS-1:0][RANK_W-1:0] rank_out
);
    rank_t sel_rank;
    assign sel_rank = rank_in[promote_way];

    for (genvar g = 0; g < WAYS; g++) begin : g_rank
        always_comb begin
            rank_out[g] = rank_in[g];
            if (promote_en) begin
                if (way_t'(g) == promote_way)
                    rank_out[g] = rank_t'(WAYS - 1);
                else if (rank_in[g] > sel_rank)
                    rank_out[g] = rank_in[g] - rank_t'(1);
            end
        end
    end
endmodule

// File: rtl/lbs_set.sv
module lbs_set
    import lbs_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_wdata,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_is_insn,
    input  logic             req_prefetch,
    output logic             hit,
    output logic             miss,
    output logic [1:0]       hit_way,
    output logic [1:0]       alloc_way
);
    localparam logic [WAYS-1:0] LOW_MASK  = {{(WAYS-HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [WAYS-1:0] HIGH_MASK = ~LOW_MASK;

    typedef struct packed {
        logic [WAYS-1:0]             valid;
        logic [WAYS-1:0][TAG_W-1:0]  tag;
        logic [WAYS-1:0][RANK_W-1:0] rank;
        logic [1:0]                  cfg;
    } state_t;

    state_t s_d, s_q;

    logic                        raw_hit;
    way_t                        raw_way;
    logic [WAYS-1:0]             elig;
    way_t                        victim;
    way_t                        touch_way;
    logic                        promote;
    logic [WAYS-1:0][RANK_W-1:0] rank_nx;

    lbs_tag_match #(.TAG_W(TAG_W)) u_match (
        .valid     (s_q.valid),
        .tags      (s_q.tag),
        .look_tag  (req_tag),
        .any_hit   (raw_hit),
        .match_way (raw_way)
    );

    always_comb begin
        if (s_q.cfg == CFG_SPLIT)
            elig = req_is_insn ? LOW_MASK : HIGH_MASK;
        else
            elig = '1;
    end

    lbs_victim_sel u_victim (
        .elig   (elig),
        .rank   (s_q.rank),
        .victim (victim)
    );

    assign touch_way = raw_hit ? raw_way : victim;
    assign promote   = req_valid && !req_prefetch;

    lbs_rank_update u_rank (
        .promote_en  (promote),
        .promote_way (touch_way),
        .rank_in     (s_q.rank),
        .rank_out    (rank_nx)
    );

    assign hit       = req_valid && raw_hit;
    assign miss      = req_valid && !raw_hit;
    assign hit_way   = hit  ? raw_way : '0;
    assign alloc_way = miss ? victim  : '0;

    always_comb begin
        s_d      = s_q;
        s_d.rank = rank_nx;
        if (cfg_we) s_d.cfg = cfg_wdata;
        if (miss) begin
            s_d.valid[victim] = 1'b1;
            s_d.tag[victim]   = req_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.valid <= '0;
            s_q.tag   <= '0;
            for (int i = 0; i < WAYS; i++) s_q.rank[i] <= rank_t'(i);
            s_q.cfg   <= CFG_POOL;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- assertions ----------------
    logic [WAYS-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < WAYS; i++) rank_seen[s_q.rank[i]] = 1'b1;
    end

    p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && !miss && hit_way == 2'd0 && alloc_way == 2'd0));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(s_q.valid) && $stable(s_q.tag) && $stable(s_q.rank)));

    p_alloc_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |-> alloc_way == 2'd0);

    p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (s_q.valid[$past(alloc_way)] && s_q.tag[$past(alloc_way)] == $past(req_tag)));

    p_rank_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rank_seen == {WAYS{1'b1}});

    p_demand_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_prefetch) |=> s_q.rank[$past(touch_way)] == rank_t'(WAYS - 1));

    p_pf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prefetch) |=> $stable(s_q.rank));

    p_split_insn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && s_q.cfg == CFG_SPLIT && req_is_insn) |-> !alloc_way[1]);

    p_split_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && s_q.cfg == CFG_SPLIT && !req_is_insn) |-> alloc_way[1]);

    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> s_q.cfg == $past(cfg_wdata));
endmodule

// File: tb/lbs_set_test.sv
module lbs_set_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_wdata;
    logic        req_valid;
    logic [15:0] req_tag;
    logic        req_is_insn;
    logic        req_prefetch;
    logic        hit, miss;
    logic [1:0]  hit_way, alloc_way;

    int n_vec  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    lbs_set #(.TAG_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_tag(req_tag), .req_is_insn(req_is_insn),
        .req_prefetch(req_prefetch), .hit(hit), .miss(miss),
        .hit_way(hit_way), .alloc_way(alloc_way)
    );

    // layout: req(4) we(1) cfg(2) val(1) insn(1) pf(1) tag(16) ehit(1) emiss(1) ehw(2) eaw(2)
    localparam int NV = 26;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {4'd3, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00A0, 1'b0,1'b1,2'd0,2'd0}, // R3 A->w0
        {4'd3, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00B0, 1'b0,1'b1,2'd0,2'd1}, // R3 B->w1
        {4'd3, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00C0, 1'b0,1'b1,2'd0,2'd2}, // R3 C->w2
        {4'd3, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00D0, 1'b0,1'b1,2'd0,2'd3}, // R3 D->w3
        {4'd2, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00A0, 1'b1,1'b0,2'd0,2'd0}, // R2 hit A
        {4'd4, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00E0, 1'b0,1'b1,2'd0,2'd1}, // R4 E->w1
        {4'd4, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h00B0, 1'b0,1'b1,2'd0,2'd2}, // R4 B evicted -> w2
        {4'd5, 1'b0,2'b00,1'b1,1'b0,1'b1,16'h00F0, 1'b0,1'b1,2'd0,2'd3}, // R5 pf F->w3
        {4'd6, 1'b0,2'b00,1'b1,1'b0,1'b1,16'h00F0, 1'b1,1'b0,2'd3,2'd0}, // R6 pf hit F
        {4'd5, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0100, 1'b0,1'b1,2'd0,2'd3}, // R5 G reuses w3
        {4'd5, 1'b0,2'b00,1'b1,1'b0,1'b1,16'h0110, 1'b0,1'b1,2'd0,2'd0}, // R5 pf H->w0
        {4'd6, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0110, 1'b1,1'b0,2'd0,2'd0}, // R6 demand hit H
        {4'd6, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0120, 1'b0,1'b1,2'd0,2'd1}, // R6 I->w1
        {4'd11,1'b0,2'b00,1'b0,1'b0,1'b0,16'h0130, 1'b0,1'b0,2'd0,2'd0}, // R11 idle
        {4'd10,1'b1,2'b10,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,2'd0,2'd0}, // R10 cfg=10
        {4'd8, 1'b0,2'b00,1'b1,1'b1,1'b0,16'h00B0, 1'b1,1'b0,2'd2,2'd0}, // R8 insn hit w2
        {4'd7, 1'b0,2'b00,1'b1,1'b1,1'b0,16'h0140, 1'b0,1'b1,2'd0,2'd0}, // R7 insn K->w0
        {4'd7, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0150, 1'b0,1'b1,2'd0,2'd3}, // R7 data L->w3
        {4'd7, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0160, 1'b0,1'b1,2'd0,2'd2}, // R7 data M->w2
        {4'd7, 1'b0,2'b00,1'b1,1'b1,1'b1,16'h0170, 1'b0,1'b1,2'd0,2'd1}, // R7 insn pf N->w1
        {4'd10,1'b1,2'b11,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,2'd0,2'd0}, // R10 cfg=11
        {4'd9, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0180, 1'b0,1'b1,2'd0,2'd1}, // R9 data Q pooled ->w1
        {4'd10,1'b1,2'b01,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,2'd0,2'd0}, // R10 cfg=01
        {4'd9, 1'b0,2'b00,1'b1,1'b0,1'b0,16'h0190, 1'b0,1'b1,2'd0,2'd0}, // R9 data R pooled ->w0
        {4'd10,1'b1,2'b00,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,2'd0,2'd0}, // R10 cfg=00
        {4'd12,1'b0,2'b00,1'b1,1'b1,1'b0,16'h0150, 1'b1,1'b0,2'd3,2'd0}  // R12 hit L, alloc 0
    };

    task automatic apply(input logic [31:0] v, input int idx);
        @(negedge clk);
        cfg_we       = v[27];
        cfg_wdata    = v[26:25];
        req_valid    = v[24];
        req_is_insn  = v[23];
        req_prefetch = v[22];
        req_tag      = v[21:6];
        #2;
        n_vec++;
        if (hit !== v[5] || miss !== v[4] || hit_way !== v[3:2] || alloc_way !== v[1:0]) begin
            n_fail++;
            $display("FAIL R%0d vec %0d: hit/miss/hw/aw actual %b/%b/%0d/%0d expected %b/%b/%0d/%0d",
                     v[31:28], idx, hit, miss, hit_way, alloc_way, v[5], v[4], v[3:2], v[1:0]);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 2'b00; req_valid = 1'b0;
        req_tag = '0; req_is_insn = 1'b0; req_prefetch = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, a fresh tag misses into way 0
        apply({4'd1,1'b0,2'b00,1'b1,1'b0,1'b1,16'h0A00, 1'b0,1'b1,2'd0,2'd0}, -1);
        for (int i = 0; i < NV; i++) apply(VEC[i], i);
        // R1: mid-run reset after split config; old tags gone, pooled order restored
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 2'b10; req_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply({4'd1,1'b0,2'b00,1'b1,1'b0,1'b0,16'h0150, 1'b0,1'b1,2'd0,2'd0}, 100);
        apply({4'd1,1'b0,2'b00,1'b1,1'b0,1'b0,16'h0160, 1'b0,1'b1,2'd0,2'd1}, 101);
        // R2: tag differing in the top bit only must miss
        apply({4'd2,1'b0,2'b00,1'b1,1'b0,1'b0,16'h8150, 1'b0,1'b1,2'd0,2'd2}, 102);
        apply({4'd2,1'b0,2'b00,1'b1,1'b0,1'b0,16'h0150, 1'b1,1'b0,2'd0,2'd0}, 103);
        // R10: write and lookup in same cycle uses the old (pooled) setting
        apply({4'd10,1'b1,2'b10,1'b1,1'b1,1'b0,16'h0200, 1'b0,1'b1,2'd0,2'd3}, 104);
        // R7: now split; instruction miss picks LRU of ways 0/1 (w1)
        apply({4'd7,1'b0,2'b00,1'b1,1'b1,1'b0,16'h0210, 1'b0,1'b1,2'd0,2'd1}, 105);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule